// File: doc/BRIEF.md
# DRAM Bank State and Residency Accounting Monitor

This block watches a merged DRAM command stream without driving anything back into it. For every accepted command it keeps an open/closed flag per bank and a device mode. From the command timestamps it accumulates how long the device spent with at least one row open, with every bank closed, in each of four power-down flavours and in self-refresh. It also adds up the exit overhead charged on each power-up, and counts activates, precharges, reads, writes and refreshes. Commands that break the expected protocol raise a one-cycle warning. A power-up that does not match the current mode raises a one-cycle error.

The refresh cycle, precharge, activate-to-column, power-down exit and DLL-relock exit times are static inputs, together with a flag that says whether a DLL is present. A power-analysis or debug fabric reads the counters continuously. Each accepted command updates every output at the clock edge that samples it.

Top module: `dram_residency_mon`

## Requirements
- R1: An activate (op 1) sets the bank's open flag and adds 1 to counter 0. If no bank was open, it adds (timestamp − last close time) to counter 6 and records the timestamp as the activation start.
- R2: A read (op 2) adds 1 to counter 2 and a write (op 3) adds 1 to counter 3. `warn` pulses for an activate to an open bank and for a read or write to a closed bank.
- R3: A single-bank precharge (op 4) adds 1 to counter 1 only if the bank was open. Closing the last open bank adds (timestamp − activation start) to counter 5 and records the close time. A precharge with no bank open adds (timestamp − last close time) to counter 6.
- R4: Precharge-all (op 5) adds the open-bank count to counter 1, or nothing when the timestamp is 0. It closes every bank and records the close time. It adds elapsed active time to counter 5 if any bank was open, and elapsed closed time to counter 6 otherwise.
- R5: Refresh (op 6) closes every bank and adds 1 to counter 4. It adds tRFC − tRP to counter 5 and (timestamp − last close time) to counter 6. It sets the last close time to timestamp + tRFC − tRP, and pulses `warn` if any bank was open.
- R6: Active power-down entry (fast op 7, slow op 8) saves the bank map, adds the elapsed active time to counter 5 and pulses `warn` if no bank was open. Active power-up (op 11) restores the saved map and the open count. It adds the time since entry to counter 7 (fast) or 8 (slow).
- R7: Power-up overhead goes to counter 11. It is tXP for a fast exit, and for a slow exit when `dll_on` is 0. It is tXPDLL − tRCD for a slow exit when `dll_on` is 1.
- R8: Precharged power-down entry (fast op 9, slow op 10) adds the elapsed closed time to counter 6 and pulses `warn` if any bank is open. Precharged power-up (op 12) adds the time since entry to counter 9 (fast) or 10 (slow), closes all banks and records the close time. An op 11 outside active power-down, or an op 12 outside precharged power-down, pulses `err`.
- R9: Every time difference is clamped at zero. Each counter saturates at all ones instead of wrapping.
- R10: `mode` codes are 0 precharged, 1 active, 2 fast active power-down, 3 slow active power-down, 4 fast precharged power-down, 5 slow precharged power-down and 6 self-refresh. While the mode is 0 or 1, it is 1 exactly when `open_cnt` is non-zero. All outputs change at the clock edge that accepts a command.
- R11: Self-refresh entry (op 13) adds the elapsed closed time to counter 6 and pulses `warn` if any bank is open. Self-refresh exit (op 14) adds the time since entry to counter 12 and returns to mode 0 with all banks closed. It pulses `err` if the mode was not 6.
- R12: After reset, all counters, flags, the bank map, the last close time and the activation start are zero, and the mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_bank | input | BW | Target bank |
| cmd_time | input | TW | Command timestamp in clock cycles |
| t_rfc | input | TW | Refresh cycle time |
| t_rp | input | TW | Precharge time |
| t_rcd | input | TW | Activate-to-column time |
| t_xp | input | TW | Power-down exit time |
| t_xpdll | input | TW | Power-down exit time with DLL relock |
| dll_on | input | 1 | Device has a DLL |
| bank_open | output | NB | Open flag per bank |
| open_cnt | output | CNTW | Number of open banks |
| mode | output | 3 | Device mode |
| warn | output | 1 | Protocol-misuse warning pulse |
| err | output | 1 | Mismatched power-up pulse |
| ctr | output | NCTR×CW | Saturating counters, index k at bits [k*CW +: CW] |

## Verification
Most state errors in this monitor stay hidden until a later command reads that state. A wrong activation start or close time only shows on the next command that closes the last bank, opens the first one, or enters power-down, as a wrong amount in counter 5 or 6. A map that is saved or restored wrongly shows on `bank_open` and `open_cnt` in the cycle after the active power-up, and then in the precharge count of a later precharge-all. A wrong mode shows at once on `mode`, and then as a spurious `err` or a missing residency amount on the next power-up or self-refresh exit. The directed sequences are therefore built so that each stored timestamp is consumed by a later command whose counter delta is checked.

// File: rtl/dram_mon_pkg.sv
// Shared encodings for the DRAM residency monitor: command codes, mode
// codes and counter indices. Assumes one command per cycle at most.
package dram_mon_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ACT   = 4'd1,
        OP_RD    = 4'd2,
        OP_WR    = 4'd3,
        OP_PRE   = 4'd4,
        OP_PREA  = 4'd5,
        OP_REF   = 4'd6,
        OP_PDA_F = 4'd7,
        OP_PDA_S = 4'd8,
        OP_PDP_F = 4'd9,
        OP_PDP_S = 4'd10,
        OP_UPA   = 4'd11,
        OP_UPP   = 4'd12,
        OP_SRE   = 4'd13,
        OP_SRX   = 4'd14
    } op_e;

    typedef enum logic [2:0] {
        M_PRE   = 3'd0,
        M_ACT   = 3'd1,
        M_PDA_F = 3'd2,
        M_PDA_S = 3'd3,
        M_PDP_F = 3'd4,
        M_PDP_S = 3'd5,
        M_SREF  = 3'd6
    } mode_e;

    localparam int NCTR     = 13;
    localparam int K_ACT    = 0;
    localparam int K_PRE    = 1;
    localparam int K_RD     = 2;
    localparam int K_WR     = 3;
    localparam int K_REF    = 4;
    localparam int K_ACTCYC = 5;
    localparam int K_PRECYC = 6;
    localparam int K_PDAF   = 7;
    localparam int K_PDAS   = 8;
    localparam int K_PDPF   = 9;
    localparam int K_PDPS   = 10;
    localparam int K_PUP    = 11;
    localparam int K_SREF   = 12;

endpackage

// File: rtl/mon_bank_map.sv
// Per-bank open flags with a shadow copy for active power-down.
// Assumes at most one of set/clear/clear-all/restore matters per cycle;
// clear-all wins over restore, and restore wins over a single-bank update.
module mon_bank_map #(
    parameter int NB   = 8,
    parameter int BW   = $clog2(NB),
    parameter int CNTW = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic            clr_en,
    input  logic            clr_all,
    input  logic            save_en,
    input  logic            restore_en,
    input  logic [BW-1:0]   idx,
    output logic [NB-1:0]   map,
    output logic [CNTW-1:0] cnt,
    output logic [CNTW-1:0] saved_cnt
);

    logic [NB-1:0] map_q;
    logic [NB-1:0] shadow_q;

    // Live map update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (clr_all) begin
            map_q <= '0;
        end else if (restore_en) begin
            map_q <= shadow_q;
        end else if (set_en) begin
            map_q[idx] <= 1'b1;
        end else if (clr_en) begin
            map_q[idx] <= 1'b0;
        end
    end

    // Shadow copy taken on active power-down entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (save_en) begin
            shadow_q <= map_q;
        end
    end

    // Population counts of the live and shadow maps.
    always_comb begin
        cnt       = '0;
        saved_cnt = '0;
        for (int i = 0; i < NB; i++) begin
            cnt       = cnt + CNTW'(map_q[i]);
            saved_cnt = saved_cnt + CNTW'(shadow_q[i]);
        end
    end

    assign map = map_q;

endmodule

// File: rtl/mon_sat_acc.sv
// Saturating accumulator: adds inc every cycle, sticks at all ones on
// overflow. Assumes inc is zero on cycles with nothing to add.
module mon_sat_acc #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] inc,
    output logic [CW-1:0] val
);

    logic [CW:0] sum;

    // Wide sum exposing the carry.
    always_comb sum = {1'b0, val} + {1'b0, inc};

    // Register with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)      val <= '0;
        else if (sum[CW]) val <= '1;
        else             val <= sum[CW-1:0];
    end

endmodule

// File: rtl/dram_residency_mon.sv
// Passive DRAM command-stream monitor: tracks bank flags and device mode,
// accumulates command counts and residency cycles from timestamps, and
// flags misuse. Assumes CW >= TW, tRFC >= tRP in normal use (clamped if
// not), and at most one command per cycle.
module dram_residency_mon
    import dram_mon_pkg::*;
#(
    parameter int NB   = 8,
    parameter int TW   = 32,
    parameter int CW   = 32,
    parameter int BW   = $clog2(NB),
    parameter int CNTW = $clog2(NB + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [3:0]               cmd_op,
    input  logic [BW-1:0]            cmd_bank,
    input  logic [TW-1:0]            cmd_time,
    input  logic [TW-1:0]            t_rfc,
    input  logic [TW-1:0]            t_rp,
    input  logic [TW-1:0]            t_rcd,
    input  logic [TW-1:0]            t_xp,
    input  logic [TW-1:0]            t_xpdll,
    input  logic                     dll_on,
    output logic [NB-1:0]            bank_open,
    output logic [CNTW-1:0]          open_cnt,
    output logic [2:0]               mode,
    output logic                     warn,
    output logic                     err,
    output logic [NCTR-1:0][CW-1:0]  ctr
);

    mode_e                  mode_q, nx_mode;
    logic [TW-1:0]          first_act, last_pre, pd_start, sr_start;
    logic [TW-1:0]          nx_first, nx_last, nx_pd, nx_sr;
    logic                   nx_warn, nx_err;
    logic [NCTR-1:0][CW-1:0] inc;
    logic                   set_en, clr_en, clr_all, save_en, restore_en;
    logic [CNTW-1:0]        cnt, saved_cnt;
    logic                   open_now, norm;
    op_e                    op;

    // Difference clamped at zero.
    function automatic logic [TW-1:0] sub0(input logic [TW-1:0] a, input logic [TW-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    mon_bank_map #(.NB(NB), .BW(BW), .CNTW(CNTW)) u_map (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
        .clr_all(clr_all), .save_en(save_en), .restore_en(restore_en),
        .idx(cmd_bank), .map(bank_open), .cnt(cnt), .saved_cnt(saved_cnt)
    );

    for (genvar k = 0; k < NCTR; k++) begin : g_acc
        mon_sat_acc #(.CW(CW)) u_acc (
            .clk(clk), .rst_n(rst_n), .inc(inc[k]), .val(ctr[k])
        );
    end

    assign op       = op_e'(cmd_op);
    assign open_now = bank_open[cmd_bank];
    assign norm     = (mode_q == M_PRE) || (mode_q == M_ACT);

    // Command decode: counter increments, map controls and next state.
    always_comb begin
        inc = '0;
        {set_en, clr_en, clr_all, save_en, restore_en} = '0;
        nx_first = first_act;
        nx_last  = last_pre;
        nx_pd    = pd_start;
        nx_sr    = sr_start;
        nx_mode  = mode_q;
        nx_warn  = 1'b0;
        nx_err   = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_ACT: begin
                    inc[K_ACT] = CW'(1);
                    nx_warn    = open_now;
                    set_en     = 1'b1;
                    if (cnt == '0) begin
                        inc[K_PRECYC] = CW'(sub0(cmd_time, last_pre));
                        nx_first      = cmd_time;
                    end
                    if (norm) nx_mode = M_ACT;
                end
                OP_RD: begin
                    inc[K_RD] = CW'(1);
                    nx_warn   = !open_now;
                end
                OP_WR: begin
                    inc[K_WR] = CW'(1);
                    nx_warn   = !open_now;
                end
                OP_PRE: begin
                    clr_en = 1'b1;
                    if (open_now) inc[K_PRE] = CW'(1);
                    if (open_now && cnt == CNTW'(1)) begin
                        inc[K_ACTCYC] = CW'(sub0(cmd_time, first_act));
                        nx_last       = cmd_time;
                        if (norm) nx_mode = M_PRE;
                    end else if (cnt == '0) begin
                        inc[K_PRECYC] = CW'(sub0(cmd_time, last_pre));
                        nx_last       = cmd_time;
                    end
                end
                OP_PREA: begin
                    clr_all = 1'b1;
                    if (cmd_time != '0) inc[K_PRE] = CW'(cnt);
                    if (cnt != '0) inc[K_ACTCYC] = CW'(sub0(cmd_time, first_act));
                    else           inc[K_PRECYC] = CW'(sub0(cmd_time, last_pre));
                    nx_last = cmd_time;
                    nx_mode = M_PRE;
                end
                OP_REF: begin
                    clr_all       = 1'b1;
                    inc[K_REF]    = CW'(1);
                    nx_warn       = (cnt != '0);
                    inc[K_PRECYC] = CW'(sub0(cmd_time, last_pre));
                    inc[K_ACTCYC] = CW'(sub0(t_rfc, t_rp));
                    nx_first      = cmd_time;
                    nx_last       = cmd_time + sub0(t_rfc, t_rp);
                    nx_mode       = M_PRE;
                end
                OP_PDA_F, OP_PDA_S: begin
                    nx_warn       = (cnt == '0);
                    save_en       = 1'b1;
                    inc[K_ACTCYC] = CW'(sub0(cmd_time, first_act));
                    nx_pd         = cmd_time;
                    nx_mode       = (op == OP_PDA_F) ? M_PDA_F : M_PDA_S;
                end
                OP_PDP_F, OP_PDP_S: begin
                    nx_warn       = (cnt != '0);
                    inc[K_PRECYC] = CW'(sub0(cmd_time, last_pre));
                    nx_pd         = cmd_time;
                    nx_mode       = (op == OP_PDP_F) ? M_PDP_F : M_PDP_S;
                end
                OP_UPA: begin
                    restore_en = 1'b1;
                    nx_first   = cmd_time;
                    if (mode_q == M_PDA_F) begin
                        inc[K_PDAF] = CW'(sub0(cmd_time, pd_start));
                        inc[K_PUP]  = CW'(t_xp);
                    end else if (mode_q == M_PDA_S) begin
                        inc[K_PDAS] = CW'(sub0(cmd_time, pd_start));
                        inc[K_PUP]  = CW'(dll_on ? sub0(t_xpdll, t_rcd) : t_xp);
                    end else begin
                        nx_err = 1'b1;
                    end
                    nx_mode = (saved_cnt != '0) ? M_ACT : M_PRE;
                end
                OP_UPP: begin
                    clr_all = 1'b1;
                    nx_last = cmd_time;
                    if (mode_q == M_PDP_F) begin
                        inc[K_PDPF] = CW'(sub0(cmd_time, pd_start));
                        inc[K_PUP]  = CW'(t_xp);
                    end else if (mode_q == M_PDP_S) begin
                        inc[K_PDPS] = CW'(sub0(cmd_time, pd_start));
                        inc[K_PUP]  = CW'(dll_on ? sub0(t_xpdll, t_rcd) : t_xp);
                    end else begin
                        nx_err = 1'b1;
                    end
                    nx_mode = M_PRE;
                end
                OP_SRE: begin
                    nx_warn       = (cnt != '0);
                    inc[K_PRECYC] = CW'(sub0(cmd_time, last_pre));
                    nx_sr         = cmd_time;
                    nx_mode       = M_SREF;
                end
                OP_SRX: begin
                    clr_all = 1'b1;
                    if (mode_q == M_SREF) inc[K_SREF] = CW'(sub0(cmd_time, sr_start));
                    else                  nx_err      = 1'b1;
                    nx_last = cmd_time;
                    nx_mode = M_PRE;
                end
                default: ;
            endcase
        end
    end

    // State and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= M_PRE;
            first_act <= '0;
            last_pre  <= '0;
            pd_start  <= '0;
            sr_start  <= '0;
            warn      <= 1'b0;
            err       <= 1'b0;
        end else begin
            mode_q    <= nx_mode;
            first_act <= nx_first;
            last_pre  <= nx_last;
            pd_start  <= nx_pd;
            sr_start  <= nx_sr;
            warn      <= nx_warn;
            err       <= nx_err;
        end
    end

    assign mode     = mode_q;
    assign open_cnt = cnt;

endmodule

// File: rtl/dram_mon_chk.sv
// Property checker for dram_residency_mon, attached by bind below.
// Watches only the top-level ports.
module dram_mon_chk
    import dram_mon_pkg::*;
#(
    parameter int NB   = 8,
    parameter int CW   = 32,
    parameter int BW   = $clog2(NB),
    parameter int CNTW = $clog2(NB + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [3:0]              cmd_op,
    input logic [BW-1:0]           cmd_bank,
    input logic [NB-1:0]           bank_open,
    input logic [CNTW-1:0]         open_cnt,
    input logic [2:0]              mode,
    input logic                    warn,
    input logic                    err,
    input logic [NCTR-1:0][CW-1:0] ctr
);

    // R1: an activate leaves its bank open.
    p_act_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT) |=> bank_open[$past(cmd_bank)]);

    // R2: a read to a closed bank warns.
    p_rd_closed_warns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RD && !bank_open[cmd_bank]) |=> warn);

    // R4: precharge-all empties the map.
    p_prea_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PREA) |=> (bank_open == '0 && open_cnt == '0));

    // R8: active power-up outside active power-down is an error.
    p_upa_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_UPA && mode != M_PDA_F && mode != M_PDA_S) |=> err);

    // R10: in the normal modes, the mode agrees with the open count.
    p_mode_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PRE || mode == M_ACT) |-> ((mode == M_ACT) == (open_cnt != '0)));

    // R9: counters never decrease.
    for (genvar k = 0; k < NCTR; k++) begin : g_mono
        p_no_decrease_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (ctr[k] >= $past(ctr[k])));
    end

endmodule

bind dram_residency_mon dram_mon_chk #(.NB(NB), .CW(CW), .BW(BW), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .bank_open(bank_open), .open_cnt(open_cnt),
    .mode(mode), .warn(warn), .err(err), .ctr(ctr)
);

// File: tb/sim_dram_residency_mon.sv
// Directed bench for dram_residency_mon: one task per scenario.
module sim_dram_residency_mon;
    import dram_mon_pkg::*;

    localparam int NB = 8;
    localparam int TW = 32;
    localparam int CW = 32;
    localparam int BW = 3;
    localparam int CNTW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [BW-1:0] cmd_bank = '0;
    logic [TW-1:0] cmd_time = '0;
    logic [TW-1:0] t_rfc = 32'd60, t_rp = 32'd10, t_rcd = 32'd12, t_xp = 32'd5, t_xpdll = 32'd40;
    logic dll_on = 1'b0;
    logic [NB-1:0] bank_open;
    logic [CNTW-1:0] open_cnt;
    logic [2:0] mode;
    logic warn, err;
    logic [NCTR-1:0][CW-1:0] ctr;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dram_residency_mon #(.NB(NB), .TW(TW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_time(cmd_time), .t_rfc(t_rfc), .t_rp(t_rp),
        .t_rcd(t_rcd), .t_xp(t_xp), .t_xpdll(t_xpdll), .dll_on(dll_on),
        .bank_open(bank_open), .open_cnt(open_cnt), .mode(mode),
        .warn(warn), .err(err), .ctr(ctr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one command; return at the falling edge after it was accepted.
    task automatic issue(input op_e o, input int b, input logic [31:0] t);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = o;
        cmd_bank = BW'(b);
        cmd_time = t;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12 map", 32'(bank_open), 0);
        chk("R12 mode", 32'(mode), 0);
        chk("R12 flags", {30'd0, warn, err}, 0);
        for (int k = 0; k < NCTR; k++) chk("R12 counter", ctr[k], 0);
    endtask

    task automatic t_act_pre();
        do_reset();
        issue(OP_ACT, 2, 100);
        chk("R1 precyc", ctr[K_PRECYC], 100);
        chk("R10 mode active", 32'(mode), 1);
        issue(OP_ACT, 5, 110);
        chk("R1 map", 32'(bank_open), 32'h24);
        chk("R1 precyc once", ctr[K_PRECYC], 100);
        issue(OP_PRE, 2, 150);
        chk("R3 actcyc not last", ctr[K_ACTCYC], 0);
        issue(OP_PRE, 5, 200);
        chk("R3 actcyc", ctr[K_ACTCYC], 100);
        chk("R3 pre count", ctr[K_PRE], 2);
        chk("R10 mode pre", 32'(mode), 0);
        issue(OP_PRE, 5, 210);
        chk("R3 closed pre", ctr[K_PRE], 2);
        chk("R3 closed precyc", ctr[K_PRECYC], 110);
        issue(OP_ACT, 1, 205);
        chk("R9 clamp", ctr[K_PRECYC], 110);
        chk("R1 act count", ctr[K_ACT], 3);
    endtask

    task automatic t_warn();
        do_reset();
        issue(OP_ACT, 3, 10);
        chk("R2 no warn", 32'(warn), 0);
        issue(OP_ACT, 3, 20);
        chk("R2 warn reopen", 32'(warn), 1);
        chk("R2 count stays", 32'(open_cnt), 1);
        issue(OP_RD, 3, 30);
        chk("R2 rd ok", 32'(warn), 0);
        chk("R2 rd count", ctr[K_RD], 1);
        issue(OP_WR, 4, 40);
        chk("R2 wr closed warn", 32'(warn), 1);
        chk("R2 wr count", ctr[K_WR], 1);
        @(negedge clk);
        chk("R2 warn pulse", 32'(warn), 0);
    endtask

    task automatic t_prea();
        do_reset();
        issue(OP_ACT, 0, 10);
        issue(OP_ACT, 1, 20);
        issue(OP_ACT, 6, 30);
        issue(OP_PREA, 0, 100);
        chk("R4 pre count", ctr[K_PRE], 3);
        chk("R4 actcyc", ctr[K_ACTCYC], 90);
        chk("R4 map", 32'(bank_open), 0);
        issue(OP_PREA, 0, 150);
        chk("R4 idle prea", ctr[K_PRE], 3);
        chk("R4 precyc", ctr[K_PRECYC], 60);
        do_reset();
        issue(OP_ACT, 0, 0);
        issue(OP_PREA, 0, 0);
        chk("R4 time zero", ctr[K_PRE], 0);
        chk("R4 time zero map", 32'(bank_open), 0);
    endtask

    task automatic t_ref();
        do_reset();
        issue(OP_ACT, 2, 40);
        issue(OP_REF, 0, 50);
        chk("R5 warn", 32'(warn), 1);
        chk("R5 ref count", ctr[K_REF], 1);
        chk("R5 actcyc", ctr[K_ACTCYC], 50);
        chk("R5 precyc", ctr[K_PRECYC], 90);
        chk("R5 map", 32'(bank_open), 0);
        issue(OP_ACT, 1, 130);
        chk("R5 last close", ctr[K_PRECYC], 120);
    endtask

    task automatic t_pd_fast();
        do_reset();
        issue(OP_ACT, 1, 10);
        issue(OP_ACT, 4, 20);
        issue(OP_PDA_F, 0, 50);
        chk("R6 entry actcyc", ctr[K_ACTCYC], 40);
        chk("R6 entry no warn", 32'(warn), 0);
        chk("R10 mode pdaf", 32'(mode), 2);
        issue(OP_PRE, 1, 60);
        chk("R6 map during pd", 32'(bank_open), 32'h10);
        issue(OP_UPA, 0, 80);
        chk("R6 restore map", 32'(bank_open), 32'h12);
        chk("R6 restore cnt", 32'(open_cnt), 2);
        chk("R6 pd fast cyc", ctr[K_PDAF], 30);
        chk("R7 fast overhead", ctr[K_PUP], 5);
        chk("R10 mode back", 32'(mode), 1);
        issue(OP_PREA, 0, 100);
        chk("R6 first act reset", ctr[K_ACTCYC], 60);
        chk("R6 restored pre count", ctr[K_PRE], 3);
    endtask

    task automatic t_pd_slow();
        do_reset();
        dll_on = 1'b1;
        issue(OP_ACT, 0, 0);
        issue(OP_PDA_S, 0, 30);
        chk("R6 slow entry", ctr[K_ACTCYC], 30);
        issue(OP_UPA, 0, 100);
        chk("R6 pd slow cyc", ctr[K_PDAS], 70);
        chk("R7 dll overhead", ctr[K_PUP], 28);
        dll_on = 1'b0;
        issue(OP_PDA_S, 0, 130);
        issue(OP_UPA, 0, 150);
        chk("R6 pd slow cyc 2", ctr[K_PDAS], 90);
        chk("R7 no dll overhead", ctr[K_PUP], 33);
        chk("R6 active total", ctr[K_ACTCYC], 60);
    endtask

    task automatic t_pd_pre();
        do_reset();
        issue(OP_PDP_F, 0, 40);
        chk("R8 entry precyc", ctr[K_PRECYC], 40);
        chk("R8 no warn", 32'(warn), 0);
        issue(OP_UPP, 0, 70);
        chk("R8 pd fast pre cyc", ctr[K_PDPF], 30);
        chk("R7 pre overhead", ctr[K_PUP], 5);
        issue(OP_UPA, 0, 80);
        chk("R8 mismatch err", 32'(err), 1);
        issue(OP_ACT, 3, 90);
        chk("R8 err pulse", 32'(err), 0);
        chk("R8 last close", ctr[K_PRECYC], 60);
        issue(OP_PDP_S, 0, 95);
        chk("R8 open warn", 32'(warn), 1);
        chk("R8 slow entry precyc", ctr[K_PRECYC], 85);
        issue(OP_UPP, 0, 120);
        chk("R8 pd slow pre cyc", ctr[K_PDPS], 25);
        chk("R8 overhead sum", ctr[K_PUP], 10);
        chk("R8 closes banks", 32'(bank_open), 0);
        chk("R8 no err", 32'(err), 0);
    endtask

    task automatic t_sref();
        do_reset();
        issue(OP_SRE, 0, 50);
        chk("R11 entry precyc", ctr[K_PRECYC], 50);
        chk("R11 mode", 32'(mode), 6);
        issue(OP_SRX, 0, 300);
        chk("R11 sref cyc", ctr[K_SREF], 250);
        chk("R11 exit mode", 32'(mode), 0);
        chk("R11 no err", 32'(err), 0);
        issue(OP_SRX, 0, 310);
        chk("R11 mismatch err", 32'(err), 1);
        chk("R11 sref kept", ctr[K_SREF], 250);
        issue(OP_ACT, 0, 320);
        chk("R11 last close", ctr[K_PRECYC], 60);
    endtask

    task automatic t_saturate();
        do_reset();
        issue(OP_PRE, 0, 32'hF000_0000);
        chk("R9 big add", ctr[K_PRECYC], 32'hF000_0000);
        issue(OP_UPP, 0, 0);
        issue(OP_PRE, 0, 32'hF000_0000);
        chk("R9 saturate", ctr[K_PRECYC], 32'hFFFF_FFFF);
        chk("R9 closed pre count", ctr[K_PRE], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_act_pre();
        t_warn();
        t_prea();
        t_ref();
        t_pd_fast();
        t_pd_slow();
        t_pd_pre();
        t_sref();
        t_saturate();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule